// File: doc/BRIEF.md
# Page-Mode Asynchronous Read Sequencer

This block sits on the host side of a pseudo-static RAM and turns single-word read requests into asynchronous read cycles on the memory pins. A request arrives on a valid/ready handshake together with a word address. The sequencer lowers chip enable, output enable and the address-valid strobe, drives the address, and waits a fixed number of system clock cycles. It then samples the 16-bit data bus and returns the word with a one-cycle valid pulse. The memory clock pin is held low throughout. The ready/wait indication that the memory drives is not used.

Sixteen consecutive words, selected by address bits [3:0], form one page. After a first read, chip enable can stay low. A following read whose bits from bit 4 upward match the open page then waits only the short page access time. A read to another page waits the full random access time. When the page-enable input is low, every read waits the full time and chip enable is released after each word. The sequencer also counts how long chip enable has been low. A read that would push the low stretch past the refresh-driven maximum first raises chip enable for one cycle and then restarts with full timing. An open page with no further requests is closed exactly at that maximum.

Top module: `psram_page_reader`

## Requirements
- R1: After reset, mem_ce_n and mem_oe_n are high, rsp_valid is low and req_ready is high.
- R2: A read accepted while chip enable is high drives chip enable low from the next cycle and holds the address for T_RAND cycles. It samples mem_dq_in in the last of those cycles and raises rsp_valid with that word in the (T_RAND+1)th cycle after the accepting edge.
- R3: With page_en high and chip enable still low from an earlier read, a read whose address bits [AW-1:4] equal those of the previous read holds its address T_PAGE cycles, and rsp_valid rises in the (T_PAGE+1)th cycle after acceptance. This holds at the in-page word offsets 0 and 15.
- R4: With chip enable still low, a read whose bits [AW-1:4] differ from the previous read waits T_RAND cycles, and chip enable stays low throughout.
- R5: With page_en low, every read takes T_RAND cycles, and chip enable is high again in the cycle where rsp_valid is high.
- R6: Chip enable is never low for more than T_CEM consecutive cycles. A read that cannot finish within that limit inserts exactly one cycle with chip enable high and then a full T_RAND access, so rsp_valid rises T_RAND+2 cycles after acceptance.
- R7: An open page that receives no request is closed after exactly T_CEM cycles of chip enable low. The next read then uses T_RAND.
- R8: Whenever chip enable is low, mem_adv_n and mem_oe_n are low. mem_clk is held low at all times.
- R9: req_ready is low from the cycle after acceptance until the word has been returned, and the address on mem_addr does not change during an access.
- R10: rsp_valid is high for one cycle for each accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| page_en | input | 1 | Allows the short in-page access time when high |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_addr | input | AW | Word address of the request |
| rsp_valid | output | 1 | One-cycle pulse marking returned data |
| rsp_data | output | 16 | Returned read word |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_adv_n | output | 1 | Memory address-valid strobe, active low |
| mem_clk | output | 1 | Memory clock, held low |
| mem_addr | output | AW | Memory word address |
| mem_dq_in | input | 16 | Memory read data bus |

## Verification
The hardest case to reach is a read that arrives while a page is open but would overrun the chip-enable limit. It must produce a single high cycle on chip enable and a longer latency. The bench reaches this case by issuing requests back to back in the same cycle each word returns, so the low stretch grows by a known amount per read. A cross-page read is placed after nine in-page hits so that its full access no longer fits. A second run of eleven hits fills the window to exactly the limit. The bench memory model returns a poison word unless the address has been stable for the access time that matches the page state. A shortened wait therefore shows up as wrong data, and the bench also measures each latency directly.

// File: rtl/psram_rd_pkg.sv
package psram_rd_pkg;

    localparam int unsigned WORD_W    = 16;
    localparam int unsigned PAGE_BITS = 4;

    typedef enum logic [1:0] {
        ST_CLOSED = 2'd0,
        ST_ACCESS = 2'd1,
        ST_OPEN   = 2'd2,
        ST_GAP    = 2'd3
    } rd_state_e;

    typedef struct packed {
        logic hit;
        logic fits;
        logic stay;
    } win_view_t;

    function automatic logic holds_ce(rd_state_e s);
        return (s == ST_ACCESS) || (s == ST_OPEN);
    endfunction

endpackage

// File: rtl/psram_page_track.sv
module psram_page_track #(
    parameter int unsigned TAG_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [TAG_W-1:0] tag_in,
    output logic [TAG_W-1:0] tag_q,
    output logic             hit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else if (capture) begin
            tag_q <= tag_in;
        end
    end

    assign hit = (tag_q == tag_in);

endmodule

// File: rtl/psram_ce_window.sv
module psram_ce_window #(
    parameter int unsigned T_CEM = 40,
    parameter int unsigned TW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_low,
    input  logic [TW-1:0] need,
    output logic          fits,
    output logic          stay_ok
);

    localparam int unsigned CW = $clog2(T_CEM + (1 << TW) + 3);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || !ce_low) begin
            low_cnt <= '0;
        end else if (low_cnt != CW'(T_CEM)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // low_cnt counts earlier low cycles; the current one adds one more
    assign fits    = (low_cnt + CW'(1) + CW'(need)) <= CW'(T_CEM);
    assign stay_ok = (low_cnt + CW'(2)) <= CW'(T_CEM);

endmodule

// File: rtl/psram_access_timer.sv
module psram_access_timer #(
    parameter int unsigned TW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] length,
    output logic          last
);

    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= length - 1'b1;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign last = (remain == '0);

endmodule

// File: rtl/psram_page_reader.sv
module psram_page_reader
    import psram_rd_pkg::*;
#(
    parameter int unsigned AW     = 21,
    parameter int unsigned T_RAND = 7,
    parameter int unsigned T_PAGE = 2,
    parameter int unsigned T_CEM  = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              page_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_adv_n,
    output logic              mem_clk,
    output logic [AW-1:0]     mem_addr,
    input  logic [WORD_W-1:0] mem_dq_in
);

    localparam int unsigned TW    = $clog2(T_RAND + 1);
    localparam int unsigned TAG_W = AW - PAGE_BITS;

    rd_state_e            state_q, state_d;
    logic [PAGE_BITS-1:0] low_q;
    logic [TAG_W-1:0]     tag_q;
    logic                 accept;
    logic                 ce_low;
    logic                 timer_load;
    logic                 timer_last;
    logic [TW-1:0]        need;
    logic [TW-1:0]        load_len;
    win_view_t            view;

    assign req_ready = (state_q == ST_CLOSED) || (state_q == ST_OPEN);
    assign accept    = req_valid && req_ready;
    assign ce_low    = holds_ce(state_q);

    assign need = (state_q == ST_OPEN && page_en && view.hit) ? TW'(T_PAGE) : TW'(T_RAND);

    psram_page_track #(.TAG_W(TAG_W)) u_track (
        .clk     (clk),
        .rst     (rst),
        .capture (accept),
        .tag_in  (req_addr[AW-1:PAGE_BITS]),
        .tag_q   (tag_q),
        .hit     (view.hit)
    );

    psram_ce_window #(.T_CEM(T_CEM), .TW(TW)) u_window (
        .clk     (clk),
        .rst     (rst),
        .ce_low  (ce_low),
        .need    (need),
        .fits    (view.fits),
        .stay_ok (view.stay)
    );

    psram_access_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (timer_load),
        .length (load_len),
        .last   (timer_last)
    );

    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        load_len   = TW'(T_RAND);
        unique case (state_q)
            ST_CLOSED: begin
                if (accept) begin
                    state_d    = ST_ACCESS;
                    timer_load = 1'b1;
                end
            end
            ST_OPEN: begin
                if (accept) begin
                    if (view.fits) begin
                        state_d    = ST_ACCESS;
                        timer_load = 1'b1;
                        load_len   = need;
                    end else begin
                        state_d = ST_GAP;
                    end
                end else if (!page_en || !view.stay) begin
                    state_d = ST_CLOSED;
                end
            end
            ST_ACCESS: begin
                if (timer_last) begin
                    state_d = (page_en && view.stay) ? ST_OPEN : ST_CLOSED;
                end
            end
            ST_GAP: begin
                state_d    = ST_ACCESS;
                timer_load = 1'b1;
            end
            default: state_d = ST_CLOSED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_CLOSED;
            low_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            state_q   <= state_d;
            rsp_valid <= 1'b0;
            if (accept) begin
                low_q <= req_addr[PAGE_BITS-1:0];
            end
            if (state_q == ST_ACCESS && timer_last) begin
                rsp_valid <= 1'b1;
                rsp_data  <= mem_dq_in;
            end
        end
    end

    assign mem_ce_n  = !ce_low;
    assign mem_oe_n  = !ce_low;
    assign mem_adv_n = !ce_low;
    assign mem_clk   = 1'b0;
    assign mem_addr  = {tag_q, low_q};

endmodule

// File: rtl/psram_page_reader_chk.sv
module psram_page_reader_chk #(
    parameter int unsigned AW    = 21,
    parameter int unsigned T_CEM = 40
) (
    input logic          clk,
    input logic          rst,
    input logic          page_en,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          mem_ce_n,
    input logic [AW-1:0] mem_addr
);

    localparam int unsigned RW = $clog2(T_CEM + 2) + 1;

    logic [RW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || mem_ce_n) begin
            low_run <= '0;
        end else if (low_run != {RW{1'b1}}) begin
            low_run <= low_run + 1'b1;
        end
    end

    assert_ce_limit_R6: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> (low_run < RW'(T_CEM)));

    assert_one_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_addr_held_R9: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !req_ready) |=> (req_ready || $stable(mem_addr)));

    assert_close_when_off_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !$past(page_en)) |-> mem_ce_n);

endmodule

bind psram_page_reader psram_page_reader_chk #(.AW(AW), .T_CEM(T_CEM)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .page_en   (page_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_ce_n  (mem_ce_n),
    .mem_addr  (mem_addr)
);

// File: tb/psram_page_reader_bench.sv
module psram_page_reader_bench;

    localparam int AW     = 21;
    localparam int T_RAND = 7;
    localparam int T_PAGE = 2;
    localparam int T_CEM  = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          page_en = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic [15:0]   rsp_data;
    logic          mem_ce_n, mem_oe_n, mem_adv_n, mem_clk;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_dq_in;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    psram_page_reader #(.AW(AW), .T_RAND(T_RAND), .T_PAGE(T_PAGE), .T_CEM(T_CEM)) u_psram_page_reader (
        .clk(clk), .rst(rst), .page_en(page_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_adv_n(mem_adv_n),
        .mem_clk(mem_clk), .mem_addr(mem_addr), .mem_dq_in(mem_dq_in)
    );

    function automatic logic [15:0] word_of(input logic [AW-1:0] a);
        return a[15:0] ^ 16'hC3A5;
    endfunction

    // memory model: data valid only after the access time that fits the page state
    logic [AW-1:0]   m_prev = '0;
    logic            m_cel = 1'b0;
    int              m_run_q = 0;
    logic [AW-5:0]   m_tag = '0;
    logic            m_tagv = 1'b0;
    int              m_run_c;
    int              m_need;

    always_comb begin
        m_run_c = (m_cel && !mem_ce_n && mem_addr == m_prev) ? m_run_q + 1 : 1;
        m_need  = (m_tagv && mem_addr[AW-1:4] == m_tag) ? T_PAGE : T_RAND;
        mem_dq_in = (!mem_ce_n && m_run_c >= m_need) ? word_of(mem_addr) : 16'hBAD0;
    end

    always @(posedge clk) begin
        m_prev  <= mem_addr;
        m_cel   <= !mem_ce_n;
        m_run_q <= mem_ce_n ? 0 : m_run_c;
        if (mem_ce_n) m_tagv <= 1'b0;
        else if (m_run_c >= m_need) begin
            m_tagv <= 1'b1;
            m_tag  <= mem_addr[AW-1:4];
        end
    end

    // pin monitor
    int run_len = 0, last_run = 0;
    int bad_limit = 0, bad_pins = 0, bad_pulse = 0;
    logic prev_rsp = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_ce_n) begin
                run_len = run_len + 1;
                if (run_len > T_CEM) bad_limit = bad_limit + 1;
                if (mem_adv_n || mem_oe_n) bad_pins = bad_pins + 1;
            end else begin
                if (run_len != 0) last_run = run_len;
                run_len = 0;
            end
            if (mem_clk !== 1'b0) bad_pins = bad_pins + 1;
            if (prev_rsp && rsp_valid) bad_pulse = bad_pulse + 1;
            prev_rsp = rsp_valid;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // bench-side prediction of latency and window state
    int   win = 0;
    logic [AW-5:0] p_tag = '0;

    task automatic predict(input logic [AW-1:0] a, output int lat, output logic gap, output logic close);
        int total, len;
        gap = 1'b0;
        if (win == 0) begin
            len = T_RAND; lat = len + 1; total = len;
        end else begin
            len = (page_en && p_tag == a[AW-1:4]) ? T_PAGE : T_RAND;
            if (win + len <= T_CEM) begin
                lat = len + 1; total = win + len;
            end else begin
                gap = 1'b1; lat = T_RAND + 2; total = T_RAND;
            end
        end
        if (page_en && total + 1 <= T_CEM) begin
            win = total + 1; close = 1'b0;
        end else begin
            win = 0; close = 1'b1;
        end
        p_tag = a[AW-1:4];
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string req);
        int exp_lat, lat;
        logic exp_gap, exp_close, saw_high;
        predict(a, exp_lat, exp_gap, exp_close);
        req_valid = 1'b1;
        req_addr  = a;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        lat = 0;
        saw_high = 1'b0;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
            if (lat == 1) check(!req_ready, "R9 ready low after accept", req_ready, 0);
            if (!rsp_valid && mem_ce_n) saw_high = 1'b1;
        end while (!rsp_valid && lat < 100);
        check(lat == exp_lat, {req, " latency"}, lat, exp_lat);
        check(rsp_data == word_of(a), {req, " data"}, rsp_data, word_of(a));
        check(saw_high == exp_gap, {req, " ce high cycle during access (R4/R6)"}, saw_high, exp_gap);
        check(mem_ce_n == exp_close, {req, " ce level at response (R5/R6)"}, mem_ce_n, exp_close);
    endtask

    task automatic close_page();
        page_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        page_en = 1'b1;
        win = 0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_oe_n, "R1 ce/oe high in reset", {mem_ce_n, mem_oe_n}, 3);
        rst = 1'b0;
        @(negedge clk);
        check(mem_ce_n == 1'b1, "R1 ce high after reset", mem_ce_n, 1);
        check(mem_oe_n == 1'b1, "R1 oe high after reset", mem_oe_n, 1);
        check(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    endtask

    task automatic t_random();
        do_read(21'h012345, "R2 first random read");
    endtask

    task automatic t_page_hits();
        do_read(21'h012340, "R3 hit offset 0");
        do_read(21'h01234F, "R3 hit offset 15");
        do_read(21'h012347, "R3 hit offset 7");
    endtask

    task automatic t_page_miss();
        do_read(21'h012350, "R4 miss on bit 4");
        do_read(21'h1F2350, "R4 miss on top bits");
        do_read(21'h1F2351, "R3 hit after miss");
    endtask

    task automatic t_disabled();
        close_page();
        page_en = 1'b0;
        do_read(21'h000300, "R5 disabled first");
        do_read(21'h000301, "R5 disabled same page");
        do_read(21'h000302, "R5 disabled same page again");
        page_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_limit();
        close_page();
        do_read(21'h000100, "R2 window start");
        for (int i = 0; i < 9; i++) do_read(21'h000100 + AW'(i + 1), "R3 window hit");
        do_read(21'h000200, "R6 miss forces gap");
        close_page();
        do_read(21'h000400, "R2 second window start");
        for (int i = 0; i < 11; i++) do_read(21'h000400 + AW'(i), "R6 fill window");
        do_read(21'h000401, "R6 read after full window");
    endtask

    task automatic t_idle_close();
        int w;
        close_page();
        do_read(21'h000800, "R7 open then idle");
        w = 0;
        while (!mem_ce_n && w < 200) begin
            @(negedge clk);
            w++;
        end
        @(negedge clk);
        check(last_run == T_CEM, "R7 idle page low run", last_run, T_CEM);
        win = 0;
        do_read(21'h000801, "R7 read after idle close");
    endtask

    task automatic t_monitors();
        check(bad_limit == 0, "R6 ce low run over limit", bad_limit, 0);
        check(bad_pins == 0, "R8 adv/oe/clk pin levels", bad_pins, 0);
        check(bad_pulse == 0, "R10 response pulse width", bad_pulse, 0);
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_random();
        t_page_hits();
        t_page_miss();
        t_disabled();
        t_limit();
        t_idle_close();
        repeat (3) @(negedge clk);
        t_monitors();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule